// File: doc/BRIEF.md
# Serial Combination Lock with Progress Hint

This block watches a single serial bit stream, one bit per clock, for a fixed eight-symbol combination. The combination is seven sampled bits 0,1,1,0,1,1,1 (oldest first) followed by a present bit of 0. The moment the present bit completes the combination, the unlock output rises in the same cycle, combinationally from the input. A second Mealy output, the hint, tells the user whether the bit now on the input is the one that takes the lock one step further toward opening.

Internally the history is held in an eight-state, three-bit register. Each state encodes how much of the combination the most recent inputs already match, and the states are numbered in binary from 0 (nothing matched) to 7 (all seven leading symbols matched). A wrong bit does not always send the machine back to the start. It falls back to the longest tail of the recent inputs that still begins the combination, so overlapping attempts are recognised. The reset is asynchronous and active-low. Its release is retimed through a short synchronizer.

Top module: `seq_lock`

## Requirements
- R1: While `rst_n_i` is low the machine is held in its idle state (nothing matched), and it clears at once without waiting for a clock edge. After `rst_n_i` rises, the machine stays idle for `RST_STAGES` rising edges before it starts to sample `x_i`.
- R2: `unlock_o` is 1 exactly when `x_i` is 0 and the seven bits sampled at the preceding seven rising edges since reset were 0,1,1,0,1,1,1, oldest first. In every other case it is 0, including the first seven bits after reset.
- R3: `unlock_o` follows `x_i` within a cycle. With the seven matching bits already taken, changing `x_i` between rising edges switches `unlock_o` without a clock edge.
- R4: Attempts overlap. The final 0 of a successful combination also counts as the first symbol of the next attempt, so a stream 0110111 repeated and then closed by 0 unlocks once every seven bits.
- R5: `hint_o` is 1 exactly when `x_i` equals the symbol that follows the longest tail of the sampled bits since reset that is also a leading part of 0,1,1,0,1,1,1,0. Every cycle with `unlock_o` high also has `hint_o` high.
- R6: On a wrong bit the match falls back to the longest tail that still begins the combination. 0110110 keeps a match of four (0110), 0111 keeps nothing, a 0 after 1 or after 0 keeps a match of one, and 0110111 followed by 1 keeps nothing.
- R7: `x_i` is sampled only at the rising edge of `clk_i`, and the outputs depend only on the sampled history and the present `x_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; `x_i` is sampled on the rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, release synchronised inside |
| x_i | input | 1 | Serial combination bit |
| unlock_o | output | 1 | High when the present bit completes the combination |
| hint_o | output | 1 | High when the present bit advances the match |

## Verification
The bench builds the block with its default two-stage reset synchronizer. It drives every 12-bit pattern back to back as one continuous 49,152-bit stream, which exercises every state with both input values many times and produces every overlap of the combination with itself. Expected outputs come from a shift register of the last seven bits and a search for the longest tail that is a leading part of the combination, so no state numbering is involved. Directed runs add repeated overlapping unlocks, the fallback from 0110110, an in-cycle toggle of the input, and a reset pulled low mid-match.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;

  localparam int unsigned STATE_W = 3;

  // Binary-coded match depth: value equals the number of symbols matched.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_M0      = 3'd1,
    ST_M01     = 3'd2,
    ST_M011    = 3'd3,
    ST_M0110   = 3'd4,
    ST_M01101  = 3'd5,
    ST_M011011 = 3'd6,
    ST_FULL    = 3'd7
  } lock_state_t;

endpackage

// File: rtl/seq_lock_rst_sync.sv
module seq_lock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/seq_lock_next.sv
module seq_lock_next
  import seq_lock_pkg::*;
(
  input  lock_state_t state_i,
  input  logic        x_i,
  output lock_state_t state_nxt_o
);

  // Advance on the wanted symbol; otherwise fall back to the longest
  // tail of the recent inputs that still starts the combination.
  always_comb begin
    state_nxt_o = ST_IDLE;
    case (state_i)
      ST_IDLE:    state_nxt_o = x_i ? ST_IDLE    : ST_M0;
      ST_M0:      state_nxt_o = x_i ? ST_M01     : ST_M0;
      ST_M01:     state_nxt_o = x_i ? ST_M011    : ST_M0;
      ST_M011:    state_nxt_o = x_i ? ST_IDLE    : ST_M0110;
      ST_M0110:   state_nxt_o = x_i ? ST_M01101  : ST_M0;
      ST_M01101:  state_nxt_o = x_i ? ST_M011011 : ST_M0;
      ST_M011011: state_nxt_o = x_i ? ST_FULL    : ST_M0110;
      ST_FULL:    state_nxt_o = x_i ? ST_IDLE    : ST_M0;
      default:    state_nxt_o = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/seq_lock_out.sv
module seq_lock_out
  import seq_lock_pkg::*;
(
  input  lock_state_t state_i,
  input  logic        x_i,
  output logic        unlock_o,
  output logic        hint_o
);

  logic want_one;

  // Symbol that advances the match from each depth.
  always_comb begin
    want_one = 1'b0;
    case (state_i)
      ST_IDLE:    want_one = 1'b0;
      ST_M0:      want_one = 1'b1;
      ST_M01:     want_one = 1'b1;
      ST_M011:    want_one = 1'b0;
      ST_M0110:   want_one = 1'b1;
      ST_M01101:  want_one = 1'b1;
      ST_M011011: want_one = 1'b1;
      ST_FULL:    want_one = 1'b0;
      default:    want_one = 1'b0;
    endcase
  end

  assign hint_o   = (x_i == want_one);
  assign unlock_o = (state_i == ST_FULL) && !x_i;

endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import seq_lock_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic x_i,
  output logic unlock_o,
  output logic hint_o
);

  logic        rst_sync_n;
  lock_state_t state_q;
  lock_state_t state_nxt;

  seq_lock_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  seq_lock_next u_next (
    .state_i     (state_q),
    .x_i         (x_i),
    .state_nxt_o (state_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

  seq_lock_out u_out (
    .state_i  (state_q),
    .x_i      (x_i),
    .unlock_o (unlock_o),
    .hint_o   (hint_o)
  );

endmodule

// File: rtl/seq_lock_chk.sv
module seq_lock_chk
  import seq_lock_pkg::*;
(
  input logic        clk_i,
  input logic        rst_sync_n,
  input logic        x_i,
  input logic        unlock_o,
  input logic        hint_o,
  input lock_state_t state_q
);

  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_sync_n |-> state_q == ST_IDLE);

  // R2
  unlock_prev_one_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (seen_q && unlock_o) |-> $past(x_i));

  // R4
  unlock_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    unlock_o |=> (state_q == ST_M0) && !unlock_o);

  // R5
  unlock_hint_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    unlock_o |-> hint_o);

  // R6
  fallback_four_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q == ST_M011011 && !x_i) |=> state_q == ST_M0110);

  // R6
  fallback_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (state_q == ST_M011 && x_i) |=> state_q == ST_IDLE);

endmodule

bind seq_lock seq_lock_chk u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .x_i        (x_i),
  .unlock_o   (unlock_o),
  .hint_o     (hint_o),
  .state_q    (state_q)
);

// File: tb/seq_lock_tb.sv
module seq_lock_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic x;
  logic unlock;
  logic hint;

  int checks = 0;
  int failures = 0;
  int unlocks = 0;
  bit done = 1'b0;

  // Seven most recent sampled bits, bit 6 oldest, and how many are valid.
  logic [6:0] hist;
  int         nseen;
  // Combination 0,1,1,0,1,1,1,0 with pat[0] first.
  localparam logic [7:0] PAT = 8'b0111_0110;

  always #4 clk = ~clk;

  seq_lock u_dut (
    .clk_i    (clk),
    .rst_n_i  (rst_n),
    .x_i      (x),
    .unlock_o (unlock),
    .hint_o   (hint)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_unlock(input logic b);
    return (nseen >= 7) && (b == 1'b0) && (hist == 7'b0110111);
  endfunction

  function automatic bit exp_hint(input logic b);
    int k;
    int lim;
    k = 0;
    lim = (nseen < 7) ? nseen : 7;
    for (int len = lim; len > 0; len--) begin
      bit same;
      same = 1'b1;
      for (int i = 0; i < len; i++) begin
        if (hist[len-1-i] != PAT[i]) same = 1'b0;
      end
      if (same) begin
        k = len;
        break;
      end
    end
    return b == PAT[k];
  endfunction

  // One serial bit: drive at falling edge, check before the next rising edge.
  task automatic step(input logic b, input bit do_chk);
    @(negedge clk);
    x = b;
    #2;
    if (do_chk) begin
      check(unlock == exp_unlock(b), "R2 unlock", int'(unlock), int'(exp_unlock(b)));
      check(hint == exp_hint(b), "R5 hint", int'(hint), int'(exp_hint(b)));
    end
    if (unlock) unlocks++;
    hist = {hist[5:0], b};
    nseen++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // Synchronizer delay: bits with value 1 leave the idle state unchanged.
    repeat (3) @(negedge clk);
    hist = '0;
    nseen = 0;
  endtask

  task automatic feed(input logic [31:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b1);
  endtask

  initial begin
    int base;
    rst_n = 1'b1;
    x = 1'b1;
    hist = '0;
    nseen = 0;
    #1 rst_n = 1'b0;
    // R1: reset state is idle, so a 0 advances and nothing unlocks
    @(negedge clk);
    x = 1'b0;
    #2;
    check(hint == 1'b1, "R1 reset hint x=0", int'(hint), 1);
    check(unlock == 1'b0, "R1 reset unlock", int'(unlock), 0);
    x = 1'b1;
    #1;
    check(hint == 1'b0, "R1 reset hint x=1", int'(hint), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: during the synchronizer delay zeros are not taken
    x = 1'b0;
    @(negedge clk);
    x = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(hint == 1'b0, "R1 held idle during release", int'(hint), 0);
    hist = '0;
    nseen = 0;

    // R4: three overlapping unlocks in 0110111 x3 followed by 0
    unlocks = 0;
    feed(32'b0110111_0110111_0110111_0, 22);
    check(unlocks == 3, "R4 overlap count", unlocks, 3);

    // R6: 0110110 falls back to 0110, then 1110 completes
    do_reset();
    unlocks = 0;
    feed(32'b0110110_1110, 11);
    check(unlocks == 1, "R6 fallback from six", unlocks, 1);
    // R6: 0111 drops the match, then a full combination still opens
    do_reset();
    unlocks = 0;
    feed(32'b0111_01101110, 12);
    check(unlocks == 1, "R6 fallback to idle", unlocks, 1);
    // R6: 0110111 then 1 gives nothing; needs a full restart
    do_reset();
    unlocks = 0;
    feed(32'b0110111_1_110111_0, 15);
    check(unlocks == 0, "R6 full then one", unlocks, 0);

    // R3: toggle x inside one cycle after 0110111
    do_reset();
    feed(32'b0110111, 7);
    @(negedge clk);
    x = 1'b1;
    #1;
    check(unlock == 1'b0, "R3 unlock with x=1", int'(unlock), 0);
    x = 1'b0;
    #1;
    check(unlock == 1'b1, "R3 unlock with x=0", int'(unlock), 1);
    x = 1'b1;
    #1;
    check(unlock == 1'b0, "R3 unlock back low", int'(unlock), 0);

    // R1: asynchronous reset mid-match clears at once
    do_reset();
    feed(32'b0110111, 7);
    @(negedge clk);
    rst_n = 1'b0;
    x = 1'b0;
    #1;
    check(unlock == 1'b0, "R1 async clear", int'(unlock), 0);
    check(hint == 1'b1, "R1 async idle hint", int'(hint), 1);
    #2 rst_n = 1'b1;
    x = 1'b1;
    repeat (3) @(negedge clk);
    hist = '0;
    nseen = 0;

    // R7, R2, R5: every 12-bit pattern back to back, one stream
    for (int v = 0; v < 4096; v++) begin
      base = v;
      feed(32'(base), 12);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule